// File: doc/BRIEF.md
# Real-Time Clock Alarm and Periodic Interrupt Unit

This block drives a single active-low interrupt line for a real-time clock. Three sources feed it. A weekly alarm compares the running day-of-week, hour and minute against its presets; its day preset is a seven-bit mask, so one alarm can cover any set of weekdays. A daily alarm compares hour and minute only. A periodic source divides an external tick strobe. It either emits a short low pulse on the line for each divided event or raises a latched request that the host must clear.

The time counters sit outside the block and present binary day (0..6), hour and minute values. The host uses a small register port with a synchronous write and a combinational read. Address 0 holds the enables and the periodic select. Address 1 holds the per-source status flags. Addresses 2 to 6 hold the presets: weekly day mask, weekly hour, weekly minute, daily hour and daily minute. The line is low while any source asserts, and reading the flags shows which source caused it.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset the line `irq_n` is 1, and both address 0 and address 1 read 0.
- R2: When the weekly enable is 1, the weekly flag (address 1 bit 1) sets on the first cycle in which three conditions hold together: the mask bit at index `cur_dow` is 1, `cur_hour` equals the weekly hour preset, and `cur_min` equals the weekly minute preset. A day whose mask bit is 0 never matches.
- R3: When the daily enable is 1, the daily flag (address 1 bit 0) sets on the first cycle in which hour and minute both equal the daily presets, whatever the day.
- R4: A flag stays set after the match ends. Writing 0 to a flag bit at address 1 clears that flag. Writing 1 to it leaves the flag unchanged.
- R5: Address 0 bit 7 is the weekly enable, bit 6 is the daily enable, and bits 2:0 are the periodic select. Other bits read 0. A select of 0 keeps the periodic source silent.
- R6: Pulse mode uses select values 1, 2 and 3, which divide the tick by 1, 2 and 4. Each divided event drives `irq_n` low for exactly PULSE_CYC cycles. Address 1 bit 2 reads 1 while the pulse is active. Any write to address 0 restarts the divider.
- R7: Level mode uses select values 4, 5, 6 and 7, which divide the tick by 1, 2, 4 and 8. Each divided event sets the periodic flag (address 1 bit 2). The flag holds `irq_n` low until the host clears it.
- R8: `irq_n` is low while at least one source asserts, and it returns high only when none asserts.
- R9: Clearing an alarm enable removes that alarm's effect on `irq_n` from the next cycle on. The stored flag is kept.
- R10: If a flag-clearing write and a new set event for the same flag happen in the same cycle, the flag ends up set.
- R11: A match that occurs while its alarm enable is 0 does not set the flag. Enabling the alarm afterwards, during the same matching minute, does not set it either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_dow | input | 3 | Current day of week, 0..6 |
| cur_hour | input | 5 | Current hour, binary 0..23 |
| cur_min | input | 6 | Current minute, binary 0..59 |
| per_tick | input | 1 | One-cycle strobe that feeds the periodic divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
An alarm set event and a host flag-clear can land in the same clock cycle. The bench provokes this by moving the time inputs onto the daily preset minute on the same negative edge where it drives a write of 0 to address 1. Reading the daily flag as 1 afterwards shows that the set won. A follow-up clear alone must then drop the flag. A second overlap occurs when both alarms match on the same minute. Here the bench removes the enables one by one and checks that the line stays low until the last enabled source is gone.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int DOW_W  = 3;
    localparam int HOUR_W = 5;
    localparam int MIN_W  = 6;
    localparam int DAYS   = 7;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int SEL_W  = 3;
    localparam int DIV_W  = 3;

    // control word bit positions
    localparam int EN_WK_BIT = 7;
    localparam int EN_DY_BIT = 6;
    // status word bit positions
    localparam int FLG_DY  = 0;
    localparam int FLG_WK  = 1;
    localparam int FLG_PER = 2;

    typedef struct packed {
        logic [DOW_W-1:0]  dow;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  minute;
    } rtc_time_t;

    typedef struct packed {
        logic [DAYS-1:0]   day_mask;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  minute;
    } alarm_preset_t;

    typedef struct packed {
        logic             wk_en;
        logic             dy_en;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL    = 3'd0,
        REG_STAT    = 3'd1,
        REG_WK_DAYS = 3'd2,
        REG_WK_HOUR = 3'd3,
        REG_WK_MIN  = 3'd4,
        REG_DY_HOUR = 3'd5,
        REG_DY_MIN  = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        PER_OFF,
        PER_PULSE,
        PER_LEVEL
    } per_mode_e;

    function automatic per_mode_e sel_mode(input logic [SEL_W-1:0] sel);
        if (sel == '0)
            return PER_OFF;
        else if (sel < SEL_W'(4))
            return PER_PULSE;
        else
            return PER_LEVEL;
    endfunction

    // terminal count of the tick divider for a given select
    function automatic logic [DIV_W-1:0] sel_period_m1(input logic [SEL_W-1:0] sel);
        logic [1:0] lg;
        case (sel_mode(sel))
            PER_PULSE: lg = 2'(sel - SEL_W'(1));
            PER_LEVEL: lg = 2'(sel - SEL_W'(4));
            default:   lg = 2'd0;
        endcase
        return DIV_W'((4'd1 << lg) - 4'd1);
    endfunction

endpackage

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
    import rtc_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [2:0]           stat_bits,
    output ctrl_t                ctrl,
    output alarm_preset_t        wk_preset,
    output alarm_preset_t        dy_preset,
    output logic                 ctrl_wr,
    output logic                 stat_wr,
    output logic [DATA_W-1:0]    rd_data
);

    logic [DAYS-1:0]   wk_days_q;
    logic [HOUR_W-1:0] wk_hour_q, dy_hour_q;
    logic [MIN_W-1:0]  wk_min_q, dy_min_q;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^wr_data[5:3];

    assign ctrl_wr = wr_en && (reg_addr_e'(wr_addr) == REG_CTRL);
    assign stat_wr = wr_en && (reg_addr_e'(wr_addr) == REG_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            wk_days_q <= '0;
            wk_hour_q <= '0;
            wk_min_q  <= '0;
            dy_hour_q <= '0;
            dy_min_q  <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_CTRL: begin
                    ctrl.wk_en <= wr_data[EN_WK_BIT];
                    ctrl.dy_en <= wr_data[EN_DY_BIT];
                    ctrl.sel   <= wr_data[SEL_W-1:0];
                end
                REG_WK_DAYS: wk_days_q <= wr_data[DAYS-1:0];
                REG_WK_HOUR: wk_hour_q <= wr_data[HOUR_W-1:0];
                REG_WK_MIN:  wk_min_q  <= wr_data[MIN_W-1:0];
                REG_DY_HOUR: dy_hour_q <= wr_data[HOUR_W-1:0];
                REG_DY_MIN:  dy_min_q  <= wr_data[MIN_W-1:0];
                default: ;
            endcase
        end
    end

    assign wk_preset = '{day_mask: wk_days_q, hour: wk_hour_q, minute: wk_min_q};
    assign dy_preset = '{day_mask: '1,        hour: dy_hour_q, minute: dy_min_q};

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            REG_CTRL: begin
                rd_data[EN_WK_BIT]   = ctrl.wk_en;
                rd_data[EN_DY_BIT]   = ctrl.dy_en;
                rd_data[SEL_W-1:0]   = ctrl.sel;
            end
            REG_STAT:    rd_data[2:0] = stat_bits;
            REG_WK_DAYS: rd_data = DATA_W'(wk_days_q);
            REG_WK_HOUR: rd_data = DATA_W'(wk_hour_q);
            REG_WK_MIN:  rd_data = DATA_W'(wk_min_q);
            REG_DY_HOUR: rd_data = DATA_W'(dy_hour_q);
            REG_DY_MIN:  rd_data = DATA_W'(dy_min_q);
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_irq_pkg::*;
#(
    parameter bit USE_DOW = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  rtc_time_t     now,
    input  alarm_preset_t preset,
    input  logic          en,
    input  logic          clr_req,
    input  logic          clr_keep,
    output logic          flag
);

    logic day_hit;
    logic match, match_q;
    logic set_evt;

    generate
        if (USE_DOW) begin : g_dow
            logic [(1<<DOW_W)-1:0] day_vec;
            assign day_vec = (1 << DOW_W)'(preset.day_mask);
            assign day_hit = day_vec[now.dow];
        end else begin : g_nodow
            logic unused_day;
            assign unused_day = ^{preset.day_mask, now.dow};
            assign day_hit    = 1'b1;
        end
    endgenerate

    assign match   = day_hit && (now.hour == preset.hour) && (now.minute == preset.minute);
    assign set_evt = en && match && !match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= 1'b0;
            flag    <= 1'b0;
        end else begin
            match_q <= match;
            if (set_evt)
                flag <= 1'b1;
            else if (clr_req && !clr_keep)
                flag <= 1'b0;
        end
    end

    // R11
    flag_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(en))
        else $error("alarm flag rose while disabled");

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !(clr_req && !clr_keep)) |=> flag)
        else $error("alarm flag dropped without a clear");

    // R10
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (en && match && !match_q && clr_req && !clr_keep) |=> flag)
        else $error("clear overrode a simultaneous set");

endmodule

// File: rtl/rtc_periodic_src.sv
module rtc_periodic_src
    import rtc_irq_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             sel_wr,
    input  logic             tick,
    input  logic             clr_req,
    input  logic             clr_keep,
    output logic             per_drive,
    output logic             per_flag
);

    localparam int PW = $clog2(PULSE_CYC + 1);

    per_mode_e        mode;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] period_m1;
    logic [PW-1:0]    pulse_cnt;
    logic             lvl_flag;
    logic             evt;
    logic             pulse_act;

    assign mode      = sel_mode(sel);
    assign period_m1 = sel_period_m1(sel);
    assign evt       = tick && (mode != PER_OFF) && (div_cnt == period_m1);
    assign pulse_act = (pulse_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst || sel_wr || mode == PER_OFF)
            div_cnt <= '0;
        else if (tick)
            div_cnt <= evt ? '0 : div_cnt + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || mode != PER_PULSE)
            pulse_cnt <= '0;
        else if (evt)
            pulse_cnt <= PW'(PULSE_CYC);
        else if (pulse_act)
            pulse_cnt <= pulse_cnt - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            lvl_flag <= 1'b0;
        else if (evt && mode == PER_LEVEL)
            lvl_flag <= 1'b1;
        else if (clr_req && !clr_keep)
            lvl_flag <= 1'b0;
    end

    assign per_drive = pulse_act || (lvl_flag && mode == PER_LEVEL);
    assign per_flag  = (mode == PER_PULSE) ? pulse_act : lvl_flag;

    // R6
    pulse_from_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_act) |-> $past(tick))
        else $error("pulse started without a tick");

    // R7
    lvl_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_flag && !(clr_req && !clr_keep)) |=> lvl_flag)
        else $error("level flag dropped without a clear");

    // R5
    per_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PER_OFF && !sel_wr) |=> !per_drive)
        else $error("periodic source active while off");

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_irq_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DOW_W-1:0]  cur_dow,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic              per_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);

    rtc_time_t     now;
    ctrl_t         ctrl;
    alarm_preset_t wk_preset, dy_preset;
    logic          ctrl_wr, stat_wr;
    logic          wk_flag, dy_flag, per_flag, per_drive;
    logic [2:0]    stat_bits;
    logic          wk_drive, dy_drive;

    assign now = '{dow: cur_dow, hour: cur_hour, minute: cur_min};

    always_comb begin
        stat_bits          = '0;
        stat_bits[FLG_DY]  = dy_flag;
        stat_bits[FLG_WK]  = wk_flag;
        stat_bits[FLG_PER] = per_flag;
    end

    rtc_irq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .stat_bits (stat_bits),
        .ctrl      (ctrl),
        .wk_preset (wk_preset),
        .dy_preset (dy_preset),
        .ctrl_wr   (ctrl_wr),
        .stat_wr   (stat_wr),
        .rd_data   (rd_data)
    );

    rtc_alarm_unit #(.USE_DOW(1'b1)) u_wk (
        .clk      (clk),
        .rst      (rst),
        .now      (now),
        .preset   (wk_preset),
        .en       (ctrl.wk_en),
        .clr_req  (stat_wr),
        .clr_keep (wr_data[FLG_WK]),
        .flag     (wk_flag)
    );

    rtc_alarm_unit #(.USE_DOW(1'b0)) u_dy (
        .clk      (clk),
        .rst      (rst),
        .now      (now),
        .preset   (dy_preset),
        .en       (ctrl.dy_en),
        .clr_req  (stat_wr),
        .clr_keep (wr_data[FLG_DY]),
        .flag     (dy_flag)
    );

    rtc_periodic_src #(.PULSE_CYC(PULSE_CYC)) u_per (
        .clk       (clk),
        .rst       (rst),
        .sel       (ctrl.sel),
        .sel_wr    (ctrl_wr),
        .tick      (per_tick),
        .clr_req   (stat_wr),
        .clr_keep  (wr_data[FLG_PER]),
        .per_drive (per_drive),
        .per_flag  (per_flag)
    );

    assign wk_drive = wk_flag && ctrl.wk_en;
    assign dy_drive = dy_flag && ctrl.dy_en;
    assign irq_n    = !(wk_drive || dy_drive || per_drive);

    // R9
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.wk_en && !ctrl.dy_en && !per_drive) |-> irq_n)
        else $error("line low with every source gated");

endmodule

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;

    localparam int CLK_P     = 10;
    localparam int PULSE_CYC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cur_dow = '0;
    logic [4:0] cur_hour = '0;
    logic [5:0] cur_min = '0;
    logic       per_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rtc_alarm_irq #(.PULSE_CYC(PULSE_CYC)) dut (
        .clk(clk), .rst(rst), .cur_dow(cur_dow), .cur_hour(cur_hour),
        .cur_min(cur_min), .per_tick(per_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_time(input logic [2:0] d, input logic [4:0] h, input logic [5:0] m);
        @(negedge clk);
        cur_dow = d; cur_hour = h; cur_min = m;
        @(negedge clk);
    endtask

    task automatic tick_once();
        @(negedge clk);
        per_tick = 1'b1;
        @(negedge clk);
        per_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 irq_n after reset", irq_n, 1);
        rd(3'd0, v); chk("R1 ctrl after reset", v, 8'h00);
        rd(3'd1, v); chk("R1 stat after reset", v, 8'h00);
    endtask

    task automatic t_daily();
        logic [7:0] v;
        wr(3'd5, 8'd7); wr(3'd6, 8'd30);
        set_time(3'd4, 5'd7, 6'd29);
        wr(3'd0, 8'h40);
        rd(3'd1, v); chk("R3 no flag before match", v, 8'h00);
        set_time(3'd4, 5'd7, 6'd30);
        rd(3'd1, v); chk("R3 daily flag on match", v, 8'h01);
        chk("R3 irq low on daily", irq_n, 0);
        set_time(3'd4, 5'd7, 6'd31);
        rd(3'd1, v); chk("R4 flag held after minute", v, 8'h01);
        wr(3'd1, 8'h07);
        rd(3'd1, v); chk("R4 write 1 keeps flag", v, 8'h01);
        wr(3'd1, 8'h06);
        rd(3'd1, v); chk("R4 write 0 clears flag", v, 8'h00);
        chk("R4 irq high after clear", irq_n, 1);
    endtask

    task automatic t_weekly();
        logic [7:0] v;
        wr(3'd2, 8'h08); wr(3'd3, 8'd9); wr(3'd4, 8'd15);
        wr(3'd0, 8'hC0);
        set_time(3'd2, 5'd9, 6'd14);
        set_time(3'd2, 5'd9, 6'd15);
        rd(3'd1, v); chk("R2 masked day no flag", v, 8'h00);
        chk("R2 irq high on masked day", irq_n, 1);
        set_time(3'd2, 5'd9, 6'd16);
        set_time(3'd3, 5'd9, 6'd15);
        rd(3'd1, v); chk("R2 weekly flag on day 3", v, 8'h02);
        chk("R2 irq low on weekly", irq_n, 0);
        wr(3'd1, 8'h05);
        rd(3'd1, v); chk("R2 weekly cleared", v, 8'h00);
        set_time(3'd3, 5'd9, 6'd16);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        wr(3'd0, 8'h00);
        wr(3'd5, 8'd7); wr(3'd6, 8'd30);
        set_time(3'd1, 5'd7, 6'd29);
        set_time(3'd1, 5'd7, 6'd30);
        rd(3'd1, v); chk("R11 no flag while disabled", v, 8'h00);
        wr(3'd0, 8'h40);
        idle(2);
        rd(3'd1, v); chk("R11 late enable no flag", v, 8'h00);
        chk("R11 irq high", irq_n, 1);
        set_time(3'd1, 5'd7, 6'd31);
    endtask

    task automatic t_both();
        logic [7:0] v;
        wr(3'd2, 8'h7F); wr(3'd3, 8'd10); wr(3'd4, 8'd0);
        wr(3'd5, 8'd10); wr(3'd6, 8'd0);
        wr(3'd0, 8'hC0);
        set_time(3'd0, 5'd9, 6'd59);
        set_time(3'd0, 5'd10, 6'd0);
        rd(3'd1, v); chk("R8 both flags set", v, 8'h03);
        chk("R8 irq low both", irq_n, 0);
        wr(3'd0, 8'h40);
        chk("R8 irq low with daily left", irq_n, 0);
        wr(3'd0, 8'h00);
        chk("R9 irq high all disabled", irq_n, 1);
        rd(3'd1, v); chk("R9 flags kept on disable", v, 8'h03);
        wr(3'd0, 8'hC0);
        chk("R9 irq low re-enabled", irq_n, 0);
        wr(3'd1, 8'h04);
        chk("R4 irq high both cleared", irq_n, 1);
        set_time(3'd0, 5'd10, 6'd1);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        wr(3'd0, 8'h40);
        wr(3'd5, 8'd11); wr(3'd6, 8'd0);
        set_time(3'd2, 5'd10, 6'd59);
        set_time(3'd2, 5'd11, 6'd0);
        set_time(3'd2, 5'd11, 6'd1);
        rd(3'd1, v); chk("R10 flag set before overlap", v, 8'h01);
        @(negedge clk);
        cur_hour = 5'd11; cur_min = 6'd0;
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd1, v); chk("R10 set wins over clear", v, 8'h01);
        chk("R10 irq low after overlap", irq_n, 0);
        wr(3'd1, 8'h00);
        rd(3'd1, v); chk("R10 lone clear works", v, 8'h00);
        set_time(3'd2, 5'd11, 6'd2);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_pulse();
        logic [7:0] v;
        int n;
        wr(3'd0, 8'h01);
        tick_once();
        chk("R6 irq low after tick", irq_n, 0);
        rd(3'd1, v); chk("R6 periodic flag during pulse", v, 8'h04);
        n = 0;
        while (!irq_n && n < 20) begin n++; @(negedge clk); end
        chk("R6 pulse length", n, PULSE_CYC);
        rd(3'd1, v); chk("R6 flag low after pulse", v, 8'h00);
        wr(3'd0, 8'h02);
        tick_once();
        chk("R6 div2 first tick silent", irq_n, 1);
        tick_once();
        chk("R6 div2 second tick pulses", irq_n, 0);
        idle(PULSE_CYC + 2);
        wr(3'd0, 8'h03);
        for (int i = 0; i < 3; i++) tick_once();
        chk("R6 div4 three ticks silent", irq_n, 1);
        tick_once();
        chk("R6 div4 fourth tick pulses", irq_n, 0);
        idle(PULSE_CYC + 2);
        chk("R6 line released", irq_n, 1);
    endtask

    task automatic t_level();
        logic [7:0] v;
        wr(3'd0, 8'h04);
        tick_once();
        rd(3'd1, v); chk("R7 level flag set", v, 8'h04);
        idle(10);
        chk("R7 irq held low", irq_n, 0);
        wr(3'd1, 8'h03);
        rd(3'd1, v); chk("R7 level flag cleared", v, 8'h00);
        chk("R7 irq high after clear", irq_n, 1);
        wr(3'd0, 8'h07);
        for (int i = 0; i < 7; i++) tick_once();
        chk("R7 div8 seven ticks silent", irq_n, 1);
        tick_once();
        chk("R7 div8 eighth tick asserts", irq_n, 0);
        wr(3'd1, 8'h00);
        chk("R7 cleared again", irq_n, 1);
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        wr(3'd0, 8'hFF);
        rd(3'd0, v); chk("R5 ctrl readback masks", v, 8'hC7);
        wr(3'd0, 8'h00);
        for (int i = 0; i < 10; i++) tick_once();
        chk("R5 sel 0 keeps line high", irq_n, 1);
        rd(3'd1, v); chk("R5 sel 0 no flag", v, 8'h00);
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_daily();
        t_weekly();
        t_disabled();
        t_both();
        t_collide();
        t_pulse();
        t_level();
        t_ctrl();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule